// File: doc/BRIEF.md
# Sample Rate to Pitch Converter

This block turns an unsigned 32-bit sample rate into a signed fixed-point base-2 logarithm that a voice engine uses as its pitch word. The rate is scaled by a fixed constant, the leading one of the scaled value sets the integer part (the octave), and the fractional part is interpolated linearly from two 128-entry constant tables: a log-magnitude table and a slope table. The tables are computed when the block is elaborated, so no table contents are written out in the source.

A request is offered with `req_valid` and accepted when `req_ready` is high. The block is driven by a three-state machine. IDLE raises `req_ready`; an accepted request takes the transition IDLE to NORM, which registers the leading-one position, the table index, the interpolation fraction and a zero flag. NORM always moves to EMIT and registers the pitch. EMIT raises `pitch_done` for one cycle and always returns to IDLE. The result thus appears two cycles after the request cycle, and one request is taken every three cycles.

Top module: `rate_pitch_conv`

## Requirements
- R1: `req_ready` is high only in IDLE. A request is accepted in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle that follows an acceptance.
- R2: `pitch_done` is high for exactly one cycle, two cycles after the acceptance cycle. It never stays high for two cycles in a row.
- R3: A rate of zero produces a pitch of zero.
- R4: The scaled value is `req_rate * 11185` modulo 2^32.
- R5: Let i be the position of the highest set bit of the scaled value, searched from 31 down to 1. Then bits 31..20 of the pitch carry the signed integer part i - 15, from -14 up to 16. A rate of 48000 gives exactly 0x00E00000.
- R6: The scaled value is shifted left by 31 - i. Bits 30..24 of the result form the table index k, and bits 23..17 form the fraction f. The pitch is ((i - 15) << 20) + M[k] + f * S[k], computed in 32-bit signed arithmetic.
- R7: M[k] is 2^20 * log2(1 + k/128) truncated, within 2 LSB. S[k] is (M[k+1] - M[k]) / 128 rounded to nearest, with M[128] = 2^20. So the result stays within a few hundred LSB of 2^20 * log2(scaled / 2^15).
- R8: When the scaled value is 1, so that no bit among 31..1 is set, the pitch is zero.
- R9: After reset, `req_ready` is 1, `pitch_done` is 0 and `pitch_out` is 0. `pitch_out` changes only at the edge that raises `pitch_done`, and holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (IDLE) |
| req_rate | input | 32 | Unsigned sample rate |
| pitch_out | output | 32 | Signed log2 pitch, 20 fraction bits |
| pitch_done | output | 1 | One-cycle pulse marking a new pitch |

## Verification
The bench sweeps every rate from 0 to 1500, every power of two, and a set of random rates. Each result is compared with a model built on real-valued logarithms. An error in the exponent or the bias moves the result by whole multiples of 2^20. An error in the index or fraction slice, or in the slope product, shows up as an interpolation error far beyond the tolerance.

Three exact corner cases are also checked:
- A rate of 48000 must give 0x00E00000. This catches a wrong scale factor or a wrong shift.
- A rate of zero must give zero.
- The modular inverse of 11185, whose scaled value is 1, must give zero. A design that lets the leading-one search reach bit 0 would return -15 << 20 instead.

The bench also checks that `pitch_done` arrives exactly two cycles after the request and that the output holds between results.

// File: rtl/rate_pitch_pkg.sv
package rate_pitch_pkg;

    localparam int RATE_W   = 32;
    localparam int LEAD_W   = 5;
    localparam int IDX_W    = 7;
    localparam int FRAC_W   = 7;
    localparam int MAG_W    = 20;
    localparam int SLOPE_W  = 8;
    localparam int TAB_N    = 1 << IDX_W;
    localparam int EXP_BIAS = 15;
    localparam logic [RATE_W-1:0] SCALE_K = 32'd11185;
    localparam int PROD_W   = FRAC_W + SLOPE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NORM = 2'd1,
        ST_EMIT = 2'd2
    } conv_state_t;

    // 2^20 * log2((128 + k) / 128) by repeated squaring, 1.0 held as 2^30.
    function automatic logic [MAG_W-1:0] log_frac(input int unsigned k);
        logic [63:0] v;
        logic [MAG_W-1:0] r;
        r = '0;
        v = 64'(TAB_N + k) << (30 - IDX_W);
        for (int b = MAG_W - 1; b >= 0; b--) begin
            v = (v * v) >> 30;
            if (v >= (64'd1 << 31)) begin
                r[b] = 1'b1;
                v = v >> 1;
            end
        end
        return r;
    endfunction

    function automatic logic [SLOPE_W-1:0] log_slope(input int unsigned k);
        logic [31:0] hi;
        logic [31:0] lo;
        lo = 32'(log_frac(k));
        hi = (k == TAB_N - 1) ? (32'd1 << MAG_W) : 32'(log_frac(k + 1));
        return SLOPE_W'((hi - lo + 32'd64) >> 7);
    endfunction

endpackage

// File: rtl/pitch_lead_norm.sv
module pitch_lead_norm
    import rate_pitch_pkg::*;
(
    input  logic [RATE_W-1:0] value,
    output logic [LEAD_W-1:0] lead,
    output logic              found,
    output logic [RATE_W-1:0] normed
);

    always_comb begin
        lead = '0;
        for (int b = 1; b < RATE_W; b++) begin
            if (value[b]) lead = LEAD_W'(b);
        end
        found  = |value[RATE_W-1:1];
        normed = value << (LEAD_W'(RATE_W - 1) - lead);
    end

endmodule

// File: rtl/pitch_log_rom.sv
module pitch_log_rom
    import rate_pitch_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    output logic [MAG_W-1:0]   mag,
    output logic [SLOPE_W-1:0] slope
);

    logic [MAG_W-1:0]   mag_tab   [TAB_N];
    logic [SLOPE_W-1:0] slope_tab [TAB_N];

    for (genvar k = 0; k < TAB_N; k++) begin : g_entry
        localparam logic [MAG_W-1:0]   MAG_K   = log_frac(k);
        localparam logic [SLOPE_W-1:0] SLOPE_K = log_slope(k);
        assign mag_tab[k]   = MAG_K;
        assign slope_tab[k] = SLOPE_K;
    end

    assign mag   = mag_tab[idx];
    assign slope = slope_tab[idx];

endmodule

// File: rtl/rate_pitch_conv.sv
module rate_pitch_conv
    import rate_pitch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_rate,
    output logic [31:0] pitch_out,
    output logic        pitch_done
);

    conv_state_t state_q, state_d;

    logic [RATE_W-1:0]  scaled;
    logic [LEAD_W-1:0]  lead_c;
    logic               found_c;
    logic [RATE_W-1:0]  normed_c;

    logic [LEAD_W-1:0]  lead_q;
    logic [IDX_W-1:0]   idx_q;
    logic [FRAC_W-1:0]  frac_q;
    logic               zero_q;

    logic [MAG_W-1:0]   mag_c;
    logic [SLOPE_W-1:0] slope_c;
    logic [PROD_W-1:0]  prod_c;
    logic signed [31:0] pitch_c;
    logic [31:0]        pitch_q;

    logic accept;

    assign scaled = req_rate * SCALE_K;
    assign accept = req_valid && (state_q == ST_IDLE);

    pitch_lead_norm u_norm (
        .value  (scaled),
        .lead   (lead_c),
        .found  (found_c),
        .normed (normed_c)
    );

    pitch_log_rom u_rom (
        .idx   (idx_q),
        .mag   (mag_c),
        .slope (slope_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_NORM;
            ST_NORM: state_d = ST_EMIT;
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready  = 1'b0;
        pitch_done = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready  = 1'b1;
            ST_NORM: ;
            ST_EMIT: pitch_done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= '0;
            idx_q  <= '0;
            frac_q <= '0;
            zero_q <= 1'b1;
        end else if (accept) begin
            lead_q <= lead_c;
            idx_q  <= normed_c[RATE_W-2 -: IDX_W];
            frac_q <= normed_c[RATE_W-2-IDX_W -: FRAC_W];
            zero_q <= !found_c;
        end
    end

    always_comb begin
        prod_c  = PROD_W'(frac_q) * PROD_W'(slope_c);
        pitch_c = ((32'(lead_q) - 32'(EXP_BIAS)) <<< MAG_W)
                + 32'(mag_c) + 32'(prod_c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   pitch_q <= '0;
        else if (state_q == ST_NORM)  pitch_q <= zero_q ? 32'd0 : pitch_c;
    end

    assign pitch_out = pitch_q;

endmodule

// File: rtl/rate_pitch_conv_chk.sv
module rate_pitch_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_rate,
    input logic [31:0] pitch_out,
    input logic        pitch_done
);

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 pitch_done);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pitch_done |=> !pitch_done);

    // R3
    zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_rate == 32'd0) |-> ##2 (pitch_out == 32'd0));

    // R5
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pitch_done |-> ($signed(pitch_out) >= -32'sd14680064 &&
                        $signed(pitch_out) <  32'sd17825792));

    // R9
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pitch_done |=> (pitch_done || $stable(pitch_out)));

endmodule

bind rate_pitch_conv rate_pitch_conv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_rate   (req_rate),
    .pitch_out  (pitch_out),
    .pitch_done (pitch_done)
);

// File: tb/rate_pitch_conv_test.sv
`timescale 1ns/1ps
module rate_pitch_conv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_rate = '0;
    logic [31:0] pitch_out;
    logic        pitch_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rate_pitch_conv uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_rate(req_rate), .pitch_out(pitch_out), .pitch_done(pitch_done)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%08h) expected=%0d (0x%08h)", req, act, act[31:0], exp, exp[31:0]);
        end
    endtask

    function automatic real lg2(input real x);
        return $ln(x) / $ln(2.0);
    endfunction

    // Model of R4..R8 with real-valued tables; returns expected pitch.
    function automatic longint model(input logic [31:0] rate);
        logic [31:0] s;
        logic [31:0] n;
        int i;
        int k;
        int f;
        real m0;
        real m1;
        longint sl;
        s = rate * 32'd11185;
        if (s < 32'd2) return 0;
        i = 0;
        for (int b = 1; b < 32; b++) if (s[b]) i = b;
        n = s << (31 - i);
        k = int'(n[30:24]);
        f = int'(n[23:17]);
        m0 = 1048576.0 * lg2(1.0 + k / 128.0);
        m1 = 1048576.0 * lg2(1.0 + (k + 1) / 128.0);
        sl = longint'((m1 - m0) / 128.0);
        return longint'(i - 15) * 1048576 + longint'(m0) + longint'(f) * sl;
    endfunction

    task automatic run_one(input logic [31:0] rate, output longint got);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_rate  = rate;
        @(negedge clk);
        req_valid = 1'b0;
        // R1: busy in the cycle after acceptance
        check("R1", req_ready == 1'b0, req_ready, 0);
        // R2: no early done
        check("R2", pitch_done == 1'b0, pitch_done, 0);
        @(negedge clk);
        // R2: done two cycles after the request cycle
        check("R2", pitch_done == 1'b1, pitch_done, 1);
        got = longint'($signed(pitch_out));
        @(negedge clk);
        // R2 single pulse, R9 hold
        check("R2", pitch_done == 1'b0, pitch_done, 0);
        check("R9", longint'($signed(pitch_out)) == got, longint'($signed(pitch_out)), got);
    endtask

    task automatic check_rate(input logic [31:0] rate);
        longint got;
        longint exp;
        longint d;
        run_one(rate, got);
        exp = model(rate);
        d = got - exp;
        if (d < 0) d = -d;
        // R5 R6 R7: within interpolation tolerance of the real-valued model
        check("R6", d <= 160, got, exp);
    endtask

    initial begin
        longint got;
        logic [31:0] inv;
        // R9 reset state
        repeat (3) @(negedge clk);
        check("R9", req_ready == 1'b1, req_ready, 1);
        check("R9", pitch_done == 1'b0, pitch_done, 0);
        check("R9", pitch_out == 32'd0, pitch_out, 0);
        rst_n = 1'b1;

        // R3 zero rate
        run_one(32'd0, got);
        check("R3", got == 0, got, 0);

        // R5 exact: 48000 gives 14 << 20
        run_one(32'd48000, got);
        check("R5", got == 64'sd14680064, got, 14680064);

        // R8: rate whose scaled value is exactly 1
        inv = 32'd11185;
        for (int it = 0; it < 6; it++) inv = inv * (32'd2 - 32'd11185 * inv);
        check("R4", (inv * 32'd11185) == 32'd1, inv * 32'd11185, 1);
        run_one(inv, got);
        check("R8", got == 0, got, 0);

        // R4 R6: all-ones rate wraps modulo 2^32
        check_rate(32'hFFFF_FFFF);
        check_rate(32'd1);

        for (int r = 2; r <= 1500; r++) check_rate(32'(r));
        for (int p = 0; p < 32; p++) check_rate(32'd1 << p);
        for (int t = 0; t < 600; t++) check_rate($urandom);

        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule